// File: doc/BRIEF.md
# Dual-Rate Serial Baud Tick Generator

This block derives two independent bit-rate strobes, one for a serial transmitter and one for a serial receiver, from the bus clock. A single shared prescaler divides the bus clock by 1, 3, 4 or 13 and produces an internal enable. Behind it, each direction has its own divider that counts prescaler enables. That divider divides by a power of two from 1 to 128. When the direction's 8-bit fine-tuning value is non-zero, the power of two is multiplied by that value.

Software programs the block through a byte-wide write port with a 2-bit register select. One register holds the prescaler code and both power-of-two codes. The other two hold the transmit and receive fine-tuning values. Each direction's divider is a two-state machine. `ST_IDLE` is entered on reset and keeps the tick low, because the divisor codes have no reset value. The transition *start* moves the divider to `ST_RUN` on the first write of the rate register. In `ST_RUN` the divider takes the transition *count* on every prescaler enable. It takes the transition *reload*, which clears its counter, whenever a write touches that direction. A write also clears the prescaler, so a new rate begins with a whole period.

Top module: `baud_tick_gen`

## Requirements
- R1: Select code 0 writes the rate register, with the prescaler code in bits 7:6, the transmit code in bits 5:3 and the receive code in bits 2:0. Select code 1 writes the transmit fine value and select code 2 writes the receive fine value. A write with select code 3 changes nothing: tick spacing and phase both continue undisturbed.
- R2: The prescaler codes 0, 1, 2 and 3 divide by 1, 3, 4 and 13 respectively.
- R3: A 3-bit divisor code c divides by 2^c, which gives 1 for code 0 and 128 for code 7.
- R4: `tx_tick` repeats every P·2^ct·F bus clocks, where F is the transmit fine value, or 1 when that value is zero. Each pulse lasts one clock whenever this period exceeds 1.
- R5: `rx_tick` follows the same rule with its own code and fine value, independently of the transmit side.
- R6: A non-zero fine value multiplies its direction's period by that value. Writing zero returns the direction to the plain power-of-two period.
- R7: After reset the prescaler code and both fine values are 0. Neither tick is raised until the rate register has been written, and writing only a fine value does not start the dividers.
- R8: After a write that touches a direction, that direction's first tick arrives exactly N clocks after the write edge. When the prescaler code is non-zero, neither tick is raised in the clock that follows a rate register write.
- R9: With a total division of 1, the tick stays high on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe, one clock per write |
| cfg_sel | input | 2 | Register select: 0 rate, 1 transmit fine, 2 receive fine, 3 none |
| cfg_data | input | 8 | Write data |
| tx_tick | output | 1 | Transmit rate strobe |
| rx_tick | output | 1 | Receive rate strobe |

## Verification
Each of the four prescaler codes is paired with fixed transmit and receive codes. Because those two codes differ, the measured spacings separate the prescaler factor from a swapped or shared divisor field. A sweep of the transmit code from 0 to 7, with the receive code mirrored from 7 to 0, separates the individual powers of two. Runs with fine values of 0, 1, 3 and 255 distinguish a bypassed multiplier from a missing one, a wrong one or one applied to the wrong direction. Further runs measure the latency from each kind of write, the reset and idle phase, a select-3 write placed in the middle of a period, and a total division of 1.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int PRE_SEL_W  = 2;
    localparam int DIV_CODE_W = 3;
    localparam int FINE_W     = 8;
    localparam int MAX_DIV    = 1 << ((1 << DIV_CODE_W) - 1);
    localparam int MAX_FINE   = (1 << FINE_W) - 1;
    localparam int DIV_CNT_W  = $clog2(MAX_DIV * MAX_FINE);
    localparam int PRE_CNT_W  = 4;

    typedef enum logic [1:0] {
        SEL_RATE    = 2'd0,
        SEL_TX_FINE = 2'd1,
        SEL_RX_FINE = 2'd2,
        SEL_NONE    = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

    function automatic logic [PRE_CNT_W-1:0] pre_factor(input logic [PRE_SEL_W-1:0] code);
        logic [PRE_CNT_W-1:0] f;
        unique case (code)
            2'd0:    f = PRE_CNT_W'(1);
            2'd1:    f = PRE_CNT_W'(3);
            2'd2:    f = PRE_CNT_W'(4);
            default: f = PRE_CNT_W'(13);
        endcase
        return f;
    endfunction
endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
    import baud_pkg::*;
#(
    parameter int SEL_W   = PRE_SEL_W,
    parameter int CODE_W  = DIV_CODE_W,
    parameter int DATA_W  = FINE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [1:0]             cfg_sel,
    input  logic [DATA_W-1:0]      cfg_data,
    output logic [SEL_W-1:0]       pre_sel,
    output logic [1:0][CODE_W-1:0] dir_code,
    output logic [1:0][DATA_W-1:0] dir_fine,
    output logic                   pre_reload,
    output logic [1:0]             dir_reload,
    output logic                   start
);
    localparam int TX_LSB  = CODE_W;
    localparam int PRE_LSB = 2 * CODE_W;

    cfg_sel_e sel;
    logic     wr_rate;
    logic     wr_tx;
    logic     wr_rx;

    always_comb begin
        sel        = cfg_sel_e'(cfg_sel);
        wr_rate    = cfg_wr && (sel == SEL_RATE);
        wr_tx      = cfg_wr && (sel == SEL_TX_FINE);
        wr_rx      = cfg_wr && (sel == SEL_RX_FINE);
        pre_reload = wr_rate || wr_tx || wr_rx;
        dir_reload = {wr_rate || wr_rx, wr_rate || wr_tx};
        start      = wr_rate;
    end

    // Prescaler code and fine values have a defined reset value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_sel  <= '0;
            dir_fine <= '0;
        end else begin
            if (wr_rate) pre_sel     <= cfg_data[PRE_LSB +: SEL_W];
            if (wr_tx)   dir_fine[0] <= cfg_data;
            if (wr_rx)   dir_fine[1] <= cfg_data;
        end
    end

    // Divisor codes carry no reset value; the dividers stay idle until written
    always_ff @(posedge clk) begin
        if (wr_rate) begin
            dir_code[0] <= cfg_data[TX_LSB +: CODE_W];
            dir_code[1] <= cfg_data[0 +: CODE_W];
        end
    end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
#(
    parameter int SEL_W = PRE_SEL_W,
    parameter int CNT_W = PRE_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [SEL_W-1:0] sel,
    output logic             pre_en
);
    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] last;

    always_comb begin
        last   = pre_factor(sel) - CNT_W'(1);
        pre_en = (pcnt == last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      pcnt <= '0;
        else if (reload) pcnt <= '0;
        else if (pre_en) pcnt <= '0;
        else             pcnt <= pcnt + CNT_W'(1);
    end
endmodule

// File: rtl/baud_dir_div.sv
module baud_dir_div
    import baud_pkg::*;
#(
    parameter int CODE_W = DIV_CODE_W,
    parameter int MUL_W  = FINE_W,
    parameter int CNT_W  = DIV_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              reload,
    input  logic              pre_en,
    input  logic [CODE_W-1:0] code,
    input  logic [MUL_W-1:0]  fine,
    output logic              tick
);
    div_state_e       state;
    div_state_e       state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mult;
    logic [CNT_W-1:0] last;
    logic             at_last;

    always_comb begin
        mult    = (fine == '0) ? CNT_W'(1) : CNT_W'(fine);
        last    = (mult << code) - CNT_W'(1);
        at_last = (cnt == last);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: start leaves idle; count and reload keep running
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (state == ST_IDLE || reload) cnt <= '0;
        else if (pre_en)                     cnt <= at_last ? '0 : cnt + CNT_W'(1);
    end

    // Outputs
    always_comb begin
        tick = 1'b0;
        unique case (state)
            ST_IDLE: tick = 1'b0;
            ST_RUN:  tick = pre_en && at_last;
        endcase
    end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int SEL_W  = PRE_SEL_W,
    parameter int CODE_W = DIV_CODE_W,
    parameter int DATA_W = FINE_W,
    parameter int PCNT_W = PRE_CNT_W,
    parameter int DCNT_W = DIV_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_data,
    output logic              tx_tick,
    output logic              rx_tick
);
    localparam int N_DIR = 2;

    logic [SEL_W-1:0]             pre_sel;
    logic [N_DIR-1:0][CODE_W-1:0] dir_code;
    logic [N_DIR-1:0][DATA_W-1:0] dir_fine;
    logic                         pre_reload;
    logic [N_DIR-1:0]             dir_reload;
    logic                         start;
    logic                         pre_en;
    logic [N_DIR-1:0]             ticks;

    baud_cfg_regs #(.SEL_W(SEL_W), .CODE_W(CODE_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_data   (cfg_data),
        .pre_sel    (pre_sel),
        .dir_code   (dir_code),
        .dir_fine   (dir_fine),
        .pre_reload (pre_reload),
        .dir_reload (dir_reload),
        .start      (start)
    );

    baud_prescaler #(.SEL_W(SEL_W), .CNT_W(PCNT_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (pre_reload),
        .sel    (pre_sel),
        .pre_en (pre_en)
    );

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        baud_dir_div #(.CODE_W(CODE_W), .MUL_W(DATA_W), .CNT_W(DCNT_W)) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (start),
            .reload (dir_reload[d]),
            .pre_en (pre_en),
            .code   (dir_code[d]),
            .fine   (dir_fine[d]),
            .tick   (ticks[d])
        );
    end

    assign tx_tick = ticks[0];
    assign rx_tick = ticks[1];
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [1:0]       cfg_sel,
    input logic [1:0]       rate_pre,
    input logic             tx_tick,
    input logic             rx_tick,
    input logic             pre_en,
    input logic [SEL_W-1:0] pre_sel
);
    logic seen_rate;

    always_ff @(posedge clk) begin
        if (!rst_n)                            seen_rate <= 1'b0;
        else if (cfg_wr && cfg_sel == 2'd0)    seen_rate <= 1'b1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_rate |-> (!tx_tick && !rx_tick)); // R7

    AST_RESET_PRESCALE: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_rate |-> (pre_sel == '0)); // R7

    AST_RELOAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == 2'd0 && rate_pre != 2'd0) |=> (!tx_tick && !rx_tick)); // R8

    AST_TX_ON_PRESCALE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |-> pre_en); // R4

    AST_RX_ON_PRESCALE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick |-> pre_en); // R5
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cfg_sel),
    .rate_pre (cfg_data[7:6]),
    .tx_tick  (tx_tick),
    .rx_tick  (rx_tick),
    .pre_en   (pre_en),
    .pre_sel  (pre_sel)
);

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_MAX   = 70000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_data = 8'd0;
    logic       tx_tick;
    logic       rx_tick;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    baud_tick_gen u_baud_tick_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .tx_tick  (tx_tick),
        .rx_tick  (rx_tick)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int exp_n(int p, int c, int f);
        int pf;
        case (p)
            0: pf = 1;
            1: pf = 3;
            2: pf = 4;
            default: pf = 13;
        endcase
        return pf * (1 << c) * ((f == 0) ? 1 : f);
    endfunction

    function automatic bit tk(bit tx);
        return tx ? tx_tick : rx_tick;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [7:0] data);
        cfg_wr   = 1'b1;
        cfg_sel  = sel;
        cfg_data = data;
        step();
        cfg_wr   = 1'b0;
    endtask

    // Clocks from the write edge to the first tick (call right after write_reg)
    task automatic latency(input bit tx, output int n);
        n = 1;
        while (!tk(tx) && n < WAIT_MAX) begin
            step();
            n++;
        end
    endtask

    // Clocks between two consecutive ticks
    task automatic interval(input bit tx, output int n);
        int guard = 0;
        while (!tk(tx) && guard < WAIT_MAX) begin
            step();
            guard++;
        end
        n = 0;
        do begin
            step();
            n++;
        end while (!tk(tx) && n < WAIT_MAX);
    endtask

    task automatic t_reset();
        int seen = 0;
        check("R7 tick low in reset", int'(tx_tick | rx_tick), 0);
        rst_n = 1'b1;
        step();
        for (int i = 0; i < 40; i++) begin
            if (tx_tick || rx_tick) seen++;
            step();
        end
        check("R7 no tick before rate write", seen, 0);
        write_reg(2'd1, 8'd5);
        for (int i = 0; i < 40; i++) begin
            if (tx_tick || rx_tick) seen++;
            step();
        end
        check("R7 fine write does not start", seen, 0);
        write_reg(2'd1, 8'd0);
    endtask

    task automatic t_prescaler();
        int n;
        for (int p = 0; p < 4; p++) begin
            write_reg(2'd0, 8'((p << 6) | (1 << 3) | 2));
            latency(1'b1, n);
            check($sformatf("R8 tx first tick p=%0d", p), n, exp_n(p, 1, 0));
            interval(1'b1, n);
            check($sformatf("R2 R4 tx period p=%0d", p), n, exp_n(p, 1, 0));
            interval(1'b0, n);
            check($sformatf("R2 R5 rx period p=%0d", p), n, exp_n(p, 2, 0));
        end
    endtask

    task automatic t_divisor_sweep();
        int n;
        for (int c = 0; c < 8; c++) begin
            write_reg(2'd0, 8'((1 << 6) | (c << 3) | (7 - c)));
            interval(1'b1, n);
            check($sformatf("R3 tx code %0d", c), n, exp_n(1, c, 0));
            interval(1'b0, n);
            check($sformatf("R3 R5 rx code %0d", 7 - c), n, exp_n(1, 7 - c, 0));
        end
    endtask

    task automatic t_pulse_width();
        int n;
        write_reg(2'd0, 8'((2 << 6) | (2 << 3) | 0));
        interval(1'b1, n);
        step();
        check("R4 tick one clock wide", int'(tx_tick), 0);
    endtask

    task automatic t_fine();
        int n;
        write_reg(2'd0, 8'((1 << 6) | (2 << 3) | 0));
        write_reg(2'd1, 8'd3);
        latency(1'b1, n);
        check("R8 tx first tick after fine write", n, exp_n(1, 2, 3));
        interval(1'b1, n);
        check("R6 tx fine 3", n, exp_n(1, 2, 3));
        interval(1'b0, n);
        check("R6 rx unaffected by tx fine", n, exp_n(1, 0, 0));
        write_reg(2'd1, 8'd1);
        interval(1'b1, n);
        check("R6 tx fine 1", n, exp_n(1, 2, 1));
        write_reg(2'd1, 8'd0);
        interval(1'b1, n);
        check("R6 tx fine back to zero", n, exp_n(1, 2, 0));
        write_reg(2'd0, 8'((0 << 6) | (0 << 3) | 7));
        write_reg(2'd2, 8'd255);
        interval(1'b0, n);
        check("R6 rx fine 255 code 7", n, exp_n(0, 7, 255));
        interval(1'b1, n);
        check("R5 tx unaffected by rx fine", n, exp_n(0, 0, 0));
        write_reg(2'd2, 8'd0);
    endtask

    task automatic t_sel_none();
        int n = 0;
        write_reg(2'd0, 8'((0 << 6) | (3 << 3) | 3));
        interval(1'b1, n);
        n = 0;
        do begin
            step();
            n++;
            cfg_wr = 1'b0;
            if (n == 2) begin
                cfg_wr   = 1'b1;
                cfg_sel  = 2'd3;
                cfg_data = 8'd0;
            end
        end while (!tx_tick && n < WAIT_MAX);
        cfg_wr = 1'b0;
        check("R1 select 3 keeps phase", n, exp_n(0, 3, 0));
        interval(1'b1, n);
        check("R1 select 3 keeps period", n, exp_n(0, 3, 0));
    endtask

    task automatic t_unit_rate();
        int hi = 0;
        write_reg(2'd0, 8'd0);
        for (int i = 0; i < 6; i++) begin
            if (tx_tick && rx_tick) hi++;
            step();
        end
        check("R9 tick every clock", hi, 6);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_prescaler();
        t_divisor_sweep();
        t_pulse_width();
        t_fine();
        t_sel_none();
        t_unit_rate();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule